// File: doc/BRIEF.md
# Dual-Port Clause 22 Management Slave

This block is the serial management slave of a PHY-side device. It watches the management clock and data line, frames IEEE 802.3 Clause 22 transactions and turns each one into a single access on a simple internal register bus. A 4-bit strapped base selects the upper four bits of the PHY address. The slave therefore answers two adjacent PHY addresses, and the lowest address bit tells the register file which of the two channels is being accessed. Both channels answer, even when only one has a datapath behind it.

The register file answers combinationally. For the register address and channel the slave presents, it returns the read data, a flag saying whether the register exists and a flag saying whether it is read-only. The slave uses these flags to enforce the access rules. A write to a missing or read-only register never produces a write strobe. A read of a missing register returns zero on the line.

MDC and MDIO are oversampled by the system clock through a synchronizer. The slave drives MDIO through a separate output value and output enable, so the pad ring can build the open line.

Top module: `mdio_c22_slave`

## Requirements
- R1: During and right after reset, mdio_oe, reg_wr and reg_rd are low.
- R2: A frame is accepted only after at least 32 consecutive 1 bits, sampled on MDC rising edges, followed by the start bits 0 then 1. A frame with only 31 preamble ones causes no strobe and no drive.
- R3: The two opcode bits, MSB first, are 10 for a read and 01 for a write. Opcodes 00 and 11 cause no strobe and no drive.
- R4: The frame is served only when PHY address bits [4:1] equal port_base[3:0]. Otherwise the slave never drives MDIO, issues no strobe and is ready for the next frame.
- R5: PHY address bit 0 appears on reg_ch (0 selects channel 0, 1 selects channel 1), and the two channels reach separate registers.
- R6: On a matching read, reg_rd pulses for exactly one clock after the last register address bit. reg_addr and reg_ch hold the address during the pulse, and mdio_oe is still low.
- R7: On a read, MDIO stays released during the first turnaround bit. The slave drives 0 for the second turnaround bit, then 16 data bits MSB first, each launched after an MDC falling edge. It releases the line at the next falling edge. The slave never drives while the master does.
- R8: A read of a register whose reg_exists is low returns 0x0000 on MDIO.
- R9: On a matching write with turnaround bits 1 then 0, the 16 data bits are collected MSB first. reg_wr pulses for exactly one clock after the last data bit, with reg_wdata, reg_addr and reg_ch valid and the address stable.
- R10: A write to a register whose reg_exists is low, or whose reg_ro is high, produces no reg_wr and leaves the register unchanged.
- R11: A write whose turnaround bits are not 1 then 0 is dropped without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples MDC |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_base | input | 4 | Strapped PHY address bits [4:1] |
| mdc | input | 1 | Management clock from the master |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable, high only while the slave drives |
| reg_addr | output | 5 | Register address of the current access |
| reg_ch | output | 1 | Channel select, taken from PHY address bit 0 |
| reg_wdata | output | 16 | Write data, valid with reg_wr |
| reg_wr | output | 1 | One-clock write strobe |
| reg_rd | output | 1 | One-clock read strobe |
| reg_rdata | input | 16 | Register read data for reg_addr and reg_ch |
| reg_exists | input | 1 | The addressed register exists |
| reg_ro | input | 1 | The addressed register is read-only |

## Verification
Two functions fall on the same MDC falling edge: the read engine releasing MDIO after the last data bit, and the master starting the preamble of the next frame. The bench provokes this with back-to-back frames that have no idle bits between them, in both directed and random sequences. It judges the result by sampling the line just before each rising edge. No bit may show the slave's enable and the master's drive together. The frame that follows must be decoded with its correct data and strobe count. A second overlap happens when the bits of a mismatched or dropped frame run straight into the next preamble. This is judged by the following frame still being served.

// File: rtl/mdio_c22_pkg.sv
package mdio_c22_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int BASE_W = ADDR_W - 1;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_OP,
    ST_ADDR,
    ST_TA_WR,
    ST_WDATA,
    ST_RD
  } frame_state_e;
endpackage

// File: rtl/mdio_c22_sync.sv
module mdio_c22_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_in,
  output logic mdc_rise,
  output logic mdc_fall,
  output logic mdio_bit
);
  logic [STAGES-1:0] mdc_s;
  logic [STAGES-1:0] mdio_s;
  logic              mdc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_s  <= '0;
      mdio_s <= '1;
      mdc_d  <= 1'b0;
    end else begin
      mdc_s  <= {mdc_s[STAGES-2:0], mdc};
      mdio_s <= {mdio_s[STAGES-2:0], mdio_in};
      mdc_d  <= mdc_s[STAGES-1];
    end
  end

  assign mdc_rise = mdc_s[STAGES-1] & ~mdc_d;
  assign mdc_fall = ~mdc_s[STAGES-1] & mdc_d;
  assign mdio_bit = mdio_s[STAGES-1];
endmodule

// File: rtl/mdio_c22_tx.sv
module mdio_c22_tx
  import mdio_c22_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              fall,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int CNT_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W + 1);

  logic              busy_q, busy_d;
  logic              oe_q, oe_d;
  logic              o_q, o_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    busy_d = busy_q;
    oe_d   = oe_q;
    o_d    = o_q;
    cnt_d  = cnt_q;
    data_d = data_q;
    if (load) begin
      busy_d = 1'b1;
      oe_d   = 1'b0;
      o_d    = 1'b0;
      cnt_d  = '0;
      data_d = load_data;
    end else if (busy_q && fall) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == '0) begin
        oe_d = 1'b0;
      end else if (cnt_q == CNT_W'(1)) begin
        oe_d = 1'b1;
        o_d  = 1'b0;
      end else if (cnt_q <= LAST_DATA) begin
        oe_d   = 1'b1;
        o_d    = data_q[DATA_W-1];
        data_d = {data_q[DATA_W-2:0], 1'b0};
      end else begin
        oe_d   = 1'b0;
        o_d    = 1'b0;
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      o_q    <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      oe_q   <= oe_d;
      o_q    <= o_d;
      cnt_q  <= cnt_d;
      data_q <= data_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
endmodule

// File: rtl/mdio_c22_fsm.sv
module mdio_c22_fsm
  import mdio_c22_pkg::*;
#(
  parameter int PRE_MIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              bit_in,
  input  logic [BASE_W-1:0] port_base,
  input  logic              tx_busy,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_ch,
  output logic [DATA_W-1:0] wdata,
  output logic              rd_pulse,
  output logic              wr_pulse
);
  localparam int PRE_BITS = $clog2(PRE_MIN + 1);
  localparam int CNT_W    = (PRE_BITS > $clog2(DATA_W)) ? PRE_BITS : $clog2(DATA_W);
  localparam int AF_W     = 2 * ADDR_W;
  localparam logic [CNT_W-1:0] PRE_CNT  = CNT_W'(PRE_MIN);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(AF_W - 1);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_W - 1);

  frame_state_e      state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              is_rd_q, is_rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ch_q, ch_d;
  logic              rd_q, rd_d;
  logic              wr_q, wr_d;
  logic [AF_W-1:0]   addr_field;
  logic [1:0]        op_field;

  assign addr_field = {sh_q[AF_W-2:0], bit_in};
  assign op_field   = {sh_q[0], bit_in};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    is_rd_d = is_rd_q;
    addr_d  = addr_q;
    ch_d    = ch_q;
    rd_d    = 1'b0;
    wr_d    = 1'b0;
    unique case (state_q)
      ST_HUNT: if (rise) begin
        if (bit_in) begin
          if (cnt_q != PRE_CNT) cnt_d = cnt_q + CNT_W'(1);
        end else begin
          if (cnt_q == PRE_CNT) state_d = ST_START;
          cnt_d = '0;
        end
      end
      ST_START: if (rise) begin
        state_d = bit_in ? ST_OP : ST_HUNT;
        cnt_d   = '0;
      end
      ST_OP: if (rise) begin
        sh_d = {sh_q[DATA_W-2:0], bit_in};
        if (cnt_q == CNT_W'(1)) begin
          cnt_d = '0;
          if (op_field == OP_READ) begin
            is_rd_d = 1'b1;
            state_d = ST_ADDR;
          end else if (op_field == OP_WRITE) begin
            is_rd_d = 1'b0;
            state_d = ST_ADDR;
          end else begin
            state_d = ST_HUNT;
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_ADDR: if (rise) begin
        sh_d = {sh_q[DATA_W-2:0], bit_in};
        if (cnt_q == ADDR_END) begin
          cnt_d = '0;
          if (addr_field[AF_W-1:ADDR_W+1] == port_base) begin
            addr_d = addr_field[ADDR_W-1:0];
            ch_d   = addr_field[ADDR_W];
            if (is_rd_q) begin
              state_d = ST_RD;
              rd_d    = 1'b1;
            end else begin
              state_d = ST_TA_WR;
            end
          end else begin
            state_d = ST_HUNT;
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_TA_WR: if (rise) begin
        if (bit_in != (cnt_q == '0)) begin
          state_d = ST_HUNT;
          cnt_d   = '0;
        end else if (cnt_q == CNT_W'(1)) begin
          state_d = ST_WDATA;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_WDATA: if (rise) begin
        sh_d = {sh_q[DATA_W-2:0], bit_in};
        if (cnt_q == DATA_END) begin
          wr_d    = 1'b1;
          state_d = ST_HUNT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_RD: if (!rd_q && !tx_busy) begin
        state_d = ST_HUNT;
        cnt_d   = '0;
      end
      default: begin
        state_d = ST_HUNT;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      sh_q    <= '0;
      is_rd_q <= 1'b0;
      addr_q  <= '0;
      ch_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      is_rd_q <= is_rd_d;
      addr_q  <= addr_d;
      ch_q    <= ch_d;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
    end
  end

  assign reg_addr = addr_q;
  assign reg_ch   = ch_q;
  assign wdata    = sh_q;
  assign rd_pulse = rd_q;
  assign wr_pulse = wr_q;
endmodule

// File: rtl/mdio_c22_slave.sv
module mdio_c22_slave
  import mdio_c22_pkg::*;
#(
  parameter int PRE_MIN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] port_base,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_ch,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_exists,
  input  logic              reg_ro
);
  logic              mdc_rise;
  logic              mdc_fall;
  logic              mdio_bit;
  logic              tx_busy;
  logic              wr_pulse;
  logic [DATA_W-1:0] rd_value;

  mdio_c22_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_in  (mdio_i),
    .mdc_rise (mdc_rise),
    .mdc_fall (mdc_fall),
    .mdio_bit (mdio_bit)
  );

  mdio_c22_fsm #(.PRE_MIN(PRE_MIN)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (mdc_rise),
    .bit_in    (mdio_bit),
    .port_base (port_base),
    .tx_busy   (tx_busy),
    .reg_addr  (reg_addr),
    .reg_ch    (reg_ch),
    .wdata     (reg_wdata),
    .rd_pulse  (reg_rd),
    .wr_pulse  (wr_pulse)
  );

  assign rd_value = reg_exists ? reg_rdata : '0;
  assign reg_wr   = wr_pulse & reg_exists & ~reg_ro;

  mdio_c22_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (reg_rd),
    .load_data (rd_value),
    .fall      (mdc_fall),
    .busy      (tx_busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );
endmodule

// File: rtl/mdio_c22_checker.sv
module mdio_c22_checker
  import mdio_c22_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_ch,
  input logic              reg_wr,
  input logic              reg_rd
);
  a_r6_rd_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  a_r6_rd_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> !mdio_oe);

  a_r9_wr_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  a_r9_addr_stable_at_wr: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ($stable(reg_addr) && $stable(reg_ch)));

  a_r7_first_driven_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  a_r7_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> !reg_wr);
endmodule

bind mdio_c22_slave mdio_c22_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .reg_addr (reg_addr),
  .reg_ch   (reg_ch),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd)
);

// File: tb/tb_mdio_c22_slave.sv
`timescale 1ns/1ps
module tb_mdio_c22_slave;
  localparam int HALF = 6;
  localparam logic [3:0] BASE = 4'hB;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mdc;
  logic        m_oe;
  logic        m_val;
  logic        bus;
  logic        mdio_o, mdio_oe;
  logic [4:0]  reg_addr;
  logic        reg_ch;
  logic [15:0] reg_wdata;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_rdata;
  logic        reg_exists, reg_ro;

  logic [15:0] regs [0:1][0:31];
  logic [15:0] expv [0:1][0:31];

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int conflicts = 0;
  bit done = 0;
  logic [4:0]  last_rd_addr, last_wr_addr;
  logic        last_rd_ch, last_wr_ch;
  logic [15:0] last_wr_data;

  logic [15:0] f_rdv;
  logic        f_ta1_oe, f_ta2_bus;
  int          f_oe_hits;

  always #10 clk = ~clk;

  assign bus        = m_oe ? m_val : (mdio_oe ? mdio_o : 1'b1);
  assign reg_exists = (reg_addr < 5'd24);
  assign reg_ro     = (reg_addr == 5'd2) || (reg_addr == 5'd3);
  assign reg_rdata  = regs[reg_ch][reg_addr];

  mdio_c22_slave dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_base  (BASE),
    .mdc        (mdc),
    .mdio_i     (bus),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .reg_addr   (reg_addr),
    .reg_ch     (reg_ch),
    .reg_wdata  (reg_wdata),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .reg_exists (reg_exists),
    .reg_ro     (reg_ro)
  );

  function automatic logic [15:0] init_val(int ch, int a);
    return 16'(32'h9100 + ch * 32'h0400 + a * 32'h0013);
  endfunction

  function automatic bit f_exists(logic [4:0] a);
    return a < 5'd24;
  endfunction

  function automatic bit f_ro(logic [4:0] a);
    return (a == 5'd2) || (a == 5'd3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 32; a++) regs[c][a] <= init_val(c, a);
    end else begin
      if (reg_wr) begin
        regs[reg_ch][reg_addr] <= reg_wdata;
        wr_cnt       <= wr_cnt + 1;
        last_wr_addr <= reg_addr;
        last_wr_ch   <= reg_ch;
        last_wr_data <= reg_wdata;
      end
      if (reg_rd) begin
        rd_cnt       <= rd_cnt + 1;
        last_rd_addr <= reg_addr;
        last_rd_ch   <= reg_ch;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bit_io(input logic drv, input logic v, output logic smp, output logic oe_s);
    @(negedge clk);
    mdc   = 1'b0;
    m_oe  = drv;
    m_val = v;
    repeat (HALF - 1) @(negedge clk);
    smp  = bus;
    oe_s = mdio_oe;
    if (drv && oe_s) conflicts++;
    mdc = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    logic s, o;
    bit_io(1'b1, v, s, o);
    if (o) f_oe_hits++;
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [1:0] ta, input logic [15:0] wd,
                       input bit rdm);
    logic s, o;
    f_oe_hits = 0;
    f_rdv     = '0;
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(op[1]);
    send_bit(op[0]);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
    if (rdm) begin
      bit_io(1'b0, 1'b1, s, o);
      f_ta1_oe = o;
      if (o) f_oe_hits++;
      bit_io(1'b0, 1'b1, s, o);
      f_ta2_bus = s;
      if (o) f_oe_hits++;
      for (int i = 0; i < 16; i++) begin
        bit_io(1'b0, 1'b1, s, o);
        if (o) f_oe_hits++;
        f_rdv = {f_rdv[14:0], s};
      end
    end else begin
      send_bit(ta[1]);
      send_bit(ta[0]);
      for (int i = 15; i >= 0; i--) send_bit(wd[i]);
    end
  endtask

  task automatic do_write(input int pre, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    frame(pre, 2'b01, phy, ra, 2'b10, wd, 1'b0);
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] ra);
    frame(32, 2'b10, phy, ra, 2'b00, 16'h0, 1'b1);
  endtask

  task automatic idle_check(input string req);
    logic s, o;
    bit_io(1'b0, 1'b1, s, o);
    chk(req, "line released after read", 32'(o), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int w0, r0, pre, ch_i;
    logic [31:0] rv;
    logic [4:0] ra, phy;
    logic [3:0] flip;
    logic ch, hit, isrd;
    logic [15:0] wd, e;
    bit doit;

    void'($urandom(32'd1234));
    mdc = 1'b0; m_oe = 1'b0; m_val = 1'b1; rst_n = 1'b0;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 32; a++) expv[c][a] = init_val(c, a);
    repeat (4) @(negedge clk);
    chk("R1", "oe in reset", 32'(mdio_oe), 32'd0);
    chk("R1", "wr in reset", 32'(reg_wr), 32'd0);
    chk("R1", "rd in reset", 32'(reg_rd), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "oe after reset", 32'(mdio_oe), 32'd0);

    // R9 basic write, channel 0
    w0 = wr_cnt;
    do_write(32, {BASE, 1'b0}, 5'd5, 16'hA5C3);
    expv[0][5] = 16'hA5C3;
    chk("R9", "write strobes", 32'(wr_cnt - w0), 32'd1);
    chk("R9", "write data", 32'(last_wr_data), 32'hA5C3);
    chk("R9", "write addr", 32'(last_wr_addr), 32'd5);
    chk("R5", "write channel 0", 32'(last_wr_ch), 32'd0);

    // R6 R7 read back
    r0 = rd_cnt;
    do_read({BASE, 1'b0}, 5'd5);
    chk("R6", "read strobes", 32'(rd_cnt - r0), 32'd1);
    chk("R6", "read addr", 32'(last_rd_addr), 32'd5);
    chk("R7", "TA1 released", 32'(f_ta1_oe), 32'd0);
    chk("R7", "TA2 zero", 32'(f_ta2_bus), 32'd0);
    chk("R7", "driven bits", 32'(f_oe_hits), 32'd17);
    chk("R7", "read data", 32'(f_rdv), 32'hA5C3);
    idle_check("R7");

    // R5 channel 1
    w0 = wr_cnt;
    do_write(32, {BASE, 1'b1}, 5'd5, 16'h3C5A);
    expv[1][5] = 16'h3C5A;
    chk("R5", "write channel 1", 32'(last_wr_ch), 32'd1);
    do_read({BASE, 1'b1}, 5'd5);
    chk("R5", "read channel 1 sel", 32'(last_rd_ch), 32'd1);
    chk("R5", "read channel 1 data", 32'(f_rdv), 32'h3C5A);
    do_read({BASE, 1'b0}, 5'd5);
    chk("R5", "channel 0 untouched", 32'(f_rdv), 32'hA5C3);

    // R8 missing register reads zero
    do_read({BASE, 1'b0}, 5'd27);
    chk("R8", "missing reg data", 32'(f_rdv), 32'd0);
    chk("R8", "missing reg driven", 32'(f_oe_hits), 32'd17);

    // R10 read-only and missing writes
    w0 = wr_cnt;
    do_write(32, {BASE, 1'b0}, 5'd2, 16'h1234);
    chk("R10", "ro write strobe", 32'(wr_cnt - w0), 32'd0);
    do_read({BASE, 1'b0}, 5'd2);
    chk("R10", "ro value kept", 32'(f_rdv), 32'(expv[0][2]));
    w0 = wr_cnt;
    do_write(32, {BASE, 1'b1}, 5'd30, 16'h5555);
    chk("R10", "missing write strobe", 32'(wr_cnt - w0), 32'd0);

    // R4 address mismatch
    w0 = wr_cnt; r0 = rd_cnt;
    do_write(32, 5'h06, 5'd5, 16'h0BAD);
    chk("R4", "mismatch write strobe", 32'(wr_cnt - w0), 32'd0);
    frame(32, 2'b10, 5'h14, 5'd5, 2'b00, 16'h0, 1'b1);
    chk("R4", "mismatch read drive", 32'(f_oe_hits), 32'd0);
    chk("R4", "mismatch read strobe", 32'(rd_cnt - r0), 32'd0);
    do_read({BASE, 1'b0}, 5'd5);
    chk("R4", "recovered and unchanged", 32'(f_rdv), 32'hA5C3);

    // R2 short preamble, after a clean write
    do_write(32, {BASE, 1'b0}, 5'd7, 16'h0001);
    expv[0][7] = 16'h0001;
    w0 = wr_cnt;
    do_write(31, {BASE, 1'b0}, 5'd6, 16'hBEEF);
    chk("R2", "31-one preamble strobe", 32'(wr_cnt - w0), 32'd0);
    do_read({BASE, 1'b0}, 5'd6);
    chk("R2", "value untouched", 32'(f_rdv), 32'(expv[0][6]));
    do_read({BASE, 1'b0}, 5'd7);
    chk("R2", "32-one preamble accepted", 32'(f_rdv), 32'h0001);

    // R3 invalid opcodes
    w0 = wr_cnt; r0 = rd_cnt;
    frame(32, 2'b11, {BASE, 1'b0}, 5'd6, 2'b10, 16'h7777, 1'b0);
    chk("R3", "opcode 11 strobes", 32'(wr_cnt - w0 + rd_cnt - r0), 32'd0);
    frame(32, 2'b00, {BASE, 1'b0}, 5'd6, 2'b00, 16'h0, 1'b1);
    chk("R3", "opcode 00 drive", 32'(f_oe_hits), 32'd0);
    chk("R3", "opcode 00 strobes", 32'(rd_cnt - r0), 32'd0);

    // R11 bad write turnaround
    w0 = wr_cnt;
    frame(32, 2'b01, {BASE, 1'b0}, 5'd8, 2'b11, 16'h1111, 1'b0);
    frame(32, 2'b01, {BASE, 1'b0}, 5'd8, 2'b00, 16'h2222, 1'b0);
    chk("R11", "bad TA strobes", 32'(wr_cnt - w0), 32'd0);
    do_read({BASE, 1'b0}, 5'd8);
    chk("R11", "value untouched", 32'(f_rdv), 32'(expv[0][8]));

    // back-to-back: release coincides with next preamble
    do_write(32, {BASE, 1'b0}, 5'd9, 16'h0F0F);
    expv[0][9] = 16'h0F0F;
    do_read({BASE, 1'b0}, 5'd9);
    chk("R7", "b2b first read", 32'(f_rdv), 32'h0F0F);
    do_read({BASE, 1'b0}, 5'd5);
    chk("R7", "b2b second read", 32'(f_rdv), 32'hA5C3);

    // constrained random mix
    for (int i = 0; i < 50; i++) begin
      rv   = $urandom;
      ch   = rv[0];
      ra   = rv[5:1];
      hit  = (rv[8:6] != 3'd0);
      isrd = rv[9];
      pre  = 32 + int'(rv[12:10]);
      flip = (rv[16:13] == 4'd0) ? 4'd1 : rv[16:13];
      wd   = rv[31:16];
      phy  = hit ? {BASE, ch} : {BASE ^ flip, ch};
      ch_i = int'(ch);
      w0 = wr_cnt; r0 = rd_cnt;
      if (isrd) begin
        frame(pre, 2'b10, phy, ra, 2'b00, 16'h0, 1'b1);
        e = f_exists(ra) ? expv[ch_i][ra] : 16'h0;
        if (hit) begin
          chk("R8", "random read data", 32'(f_rdv), 32'(e));
          chk("R6", "random read strobe", 32'(rd_cnt - r0), 32'd1);
        end else begin
          chk("R4", "random mismatch drive", 32'(f_oe_hits), 32'd0);
        end
      end else begin
        frame(pre, 2'b01, phy, ra, 2'b10, wd, 1'b0);
        doit = hit && f_exists(ra) && !f_ro(ra);
        if (doit) expv[ch_i][ra] = wd;
        chk("R10", "random write strobe", 32'(wr_cnt - w0), doit ? 32'd1 : 32'd0);
      end
    end

    chk("R7", "master/slave drive overlap", 32'(conflicts), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule